// File: doc/BRIEF.md
# Auto-Increment SRAM Data Port

This block gives a host indirect access to a local 16-bit SRAM through two registers: an address pointer and a data port. The host loads the pointer once. Each data-port access then moves the pointer forward, so buffers can be streamed in ascending order without rewriting the pointer. The block shares the SRAM's single port with a network-side requester, and that requester always wins.

A data-port write is latched into a one-entry post register and the host cycle ends at once. The SRAM is written later, whenever the port is free. After each data-port read, the block fetches the following word in the background. A later read that matches that word completes with no wait. Any private-bus activity other than an SRAM read throws the fetched word away. A ready output holds the host cycle for as long as the block needs.

Top module: `sram_dport`

## Requirements
- R1: A host write with the pointer select high loads the byte pointer from `h_wdata` and completes with no wait. A host read with the pointer select high returns the pointer, zero-extended, with no wait. After reset the pointer is 0.
- R2: Every completed data-port access advances the pointer, by 2 for a word access and by 1 for a byte access.
- R3: A data-port write completes with no wait when the post register is empty. The data is written to SRAM later. A word write fills both lanes. A byte write to an even address fills bits 7:0, and a byte write to an odd address fills bits 15:8.
- R4: A data-port write that arrives while the post register still holds unwritten data keeps `h_ready` low until that data has been written to SRAM.
- R5: A data-port read that misses the prefetch holds `h_ready` low while the block issues a direct SRAM read. It completes in the cycle after the SRAM read is issued.
- R6: After each data-port read, the word containing the new pointer is fetched in the background. A word read that hits this valid prefetch completes with no wait and returns the prefetched word.
- R7: A byte read that hits a valid prefetch completes with no wait. It returns the byte selected by pointer bit 0 (0 selects bits 7:0, 1 selects bits 15:8) in bits 7:0, with the upper bits zero.
- R8: The following events discard the prefetch, so the next read misses: a pointer write, a host data write or its retirement to SRAM, a network write, and a pulse on `aux_act`. A network read leaves the prefetch valid.
- R9: A pending posted write is written to SRAM before any SRAM read, so a read always sees the latest data.
- R10: A network request takes the SRAM port in the same cycle, ahead of write retirement, host reads and prefetch. Network read data appears on `n_rdata` with `n_rvalid` one cycle later.
- R11: After reset the post register is empty and the prefetch is invalid, so the first data-port read misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host cycle active; held until completed with h_ready |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_sel_ptr | input | 1 | 1 = pointer register, 0 = data port |
| h_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| h_wdata | input | 16 | Host write data (byte data in bits 7:0) |
| h_rdata | output | 16 | Host read data, valid while h_ready is high |
| h_ready | output | 1 | Host cycle completes at the clock edge where h_req and h_ready are both high |
| aux_act | input | 1 | Other private-bus activity, such as a PROM read |
| n_req | input | 1 | Network SRAM request |
| n_wr | input | 1 | Network write |
| n_addr | input | AW | Network word address |
| n_wdata | input | 16 | Network write data |
| n_rdata | output | 16 | Network read data |
| n_rvalid | output | 1 | n_rdata valid |
| mem_en | output | 1 | SRAM enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM word address |
| mem_be | output | 2 | SRAM byte enables |
| mem_wdata | output | 16 | SRAM write data |
| mem_rdata | input | 16 | SRAM read data, one cycle after a read enable |

## Verification
The bench checks that a word fetched in the background is discarded by each event that should discard it. If the block kept a stale word after a network write, the bench would read old data with no wait. It also checks that a network read keeps the word, since a block that dropped it would add a wait. A read issued right behind a write must wait two cycles for the retirement, or it would return the old memory contents. Two byte reads from the same prefetched word check lane selection: swapped lanes return the wrong byte. A second write issued while the network holds the port checks the stall: a block that overwrote the post register would lose the first word.

// File: rtl/sram_dport.sv
module sram_dport #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req,
  input  logic          h_wr,
  input  logic          h_sel_ptr,
  input  logic          h_word,
  input  logic [15:0]   h_wdata,
  output logic [15:0]   h_rdata,
  output logic          h_ready,
  input  logic          aux_act,
  input  logic          n_req,
  input  logic          n_wr,
  input  logic [AW-1:0] n_addr,
  input  logic [15:0]   n_wdata,
  output logic [15:0]   n_rdata,
  output logic          n_rvalid,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int PW = AW + 1;

  typedef enum logic [1:0] {RK_NONE, RK_HOST, RK_PF, RK_NET} rkind_t;

  logic [PW-1:0] ptr;
  logic          post_v, post_word;
  logic [PW-1:0] post_addr;
  logic [15:0]   post_data;
  logic          pf_v, pf_want;
  logic [AW-1:0] pf_addr, pf_want_addr, rd_addr;
  logic [15:0]   pf_data;
  rkind_t        rk;

  wire h_dat = h_req & ~h_sel_ptr;
  wire h_rd  = h_dat & ~h_wr;
  wire h_wt  = h_dat & h_wr;
  wire p_wr  = h_req & h_sel_ptr & h_wr;
  wire [AW-1:0] ptr_w = ptr[PW-1:1];
  wire [PW-1:0] ptr_nx = ptr + {{(PW-2){1'b0}}, h_word, ~h_word};
  wire hit = pf_v & (pf_addr == ptr_w);

  wire ret_go = post_v & ~n_req;
  wire hrd_go = h_rd & ~hit & (rk != RK_HOST) & ~post_v & ~n_req;

  assign h_ready = h_sel_ptr ? 1'b1 :
                   h_wr      ? (~post_v | ret_go) :
                               (hit | (rk == RK_HOST));

  wire wacc = h_wt & h_ready;
  wire racc = h_rd & h_ready;
  wire inv  = p_wr | wacc | ret_go | (n_req & n_wr) | aux_act;
  wire pf_go = pf_want & ~n_req & ~post_v & ~hrd_go & ~inv;

  wire [15:0] src = (rk == RK_HOST) ? mem_rdata : pf_data;
  always_comb begin
    if (h_sel_ptr)   h_rdata = {{(16-PW){1'b0}}, ptr};
    else if (h_word) h_rdata = src;
    else             h_rdata = {8'h00, ptr[0] ? src[15:8] : src[7:0]};
  end

  always_comb begin
    mem_en    = n_req | ret_go | hrd_go | pf_go;
    mem_we    = 1'b0;
    mem_addr  = pf_want_addr;
    mem_be    = 2'b11;
    mem_wdata = n_wdata;
    if (n_req) begin
      mem_we   = n_wr;
      mem_addr = n_addr;
    end else if (ret_go) begin
      mem_we    = 1'b1;
      mem_addr  = post_addr[PW-1:1];
      mem_be    = post_word ? 2'b11 : (post_addr[0] ? 2'b10 : 2'b01);
      mem_wdata = post_word ? post_data : {2{post_data[7:0]}};
    end else if (hrd_go) begin
      mem_addr = ptr_w;
    end
  end

  assign n_rdata = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr          <= '0;
      post_v       <= 1'b0;
      post_word    <= 1'b0;
      post_addr    <= '0;
      post_data    <= '0;
      pf_v         <= 1'b0;
      pf_want      <= 1'b0;
      pf_addr      <= '0;
      pf_want_addr <= '0;
      pf_data      <= '0;
      rd_addr      <= '0;
      rk           <= RK_NONE;
      n_rvalid     <= 1'b0;
    end else begin
      if (p_wr)              ptr <= h_wdata[PW-1:0];
      else if (wacc | racc)  ptr <= ptr_nx;

      if (wacc) begin
        post_v    <= 1'b1;
        post_addr <= ptr;
        post_word <= h_word;
        post_data <= h_wdata;
      end else if (ret_go) begin
        post_v <= 1'b0;
      end

      if (racc) begin
        pf_want      <= 1'b1;
        pf_want_addr <= ptr_nx[PW-1:1];
      end else if (inv | pf_go) begin
        pf_want <= 1'b0;
      end

      if (inv) begin
        pf_v <= 1'b0;
      end else if (rk == RK_PF) begin
        pf_v    <= 1'b1;
        pf_addr <= rd_addr;
        pf_data <= mem_rdata;
      end

      rd_addr  <= mem_addr;
      n_rvalid <= n_req & ~n_wr;
      if (n_req)       rk <= n_wr ? RK_NONE : RK_NET;
      else if (hrd_go) rk <= RK_HOST;
      else if (pf_go)  rk <= RK_PF;
      else             rk <= RK_NONE;
    end
  end

  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (h_dat && h_ready && h_word) |=> ptr == $past(ptr) + 2'd2);
  a_r3_post_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wt && h_ready) |=> post_v && post_data == $past(h_wdata));
  a_r4_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wt && post_v && n_req) |-> !h_ready);
  a_r6_word_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_word && pf_v && pf_addr == ptr_w) |-> h_ready && h_rdata == pf_data);
  a_r8_ptr_wr_kills: assert property (@(posedge clk) disable iff (!rst_n)
    p_wr |=> !pf_v);
  a_r9_read_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && !n_req) |-> !post_v);
  a_r10_net_first: assert property (@(posedge clk) disable iff (!rst_n)
    n_req |-> (mem_en && mem_addr == n_addr && mem_we == n_wr));
endmodule

// File: tb/sram_dport_test.sv
module sram_dport_test;
  localparam int AW = 10;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic h_req = 0, h_wr = 0, h_sel_ptr = 0, h_word = 0, aux_act = 0;
  logic [15:0] h_wdata = 0, h_rdata;
  logic h_ready;
  logic n_req = 0, n_wr = 0, n_rvalid;
  logic [AW-1:0] n_addr = 0;
  logic [15:0] n_wdata = 0, n_rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [0:(1<<AW)-1];
  int tests = 0, fails = 0;

  sram_dport #(.AW(AW)) uut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= '0;
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
      end else mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hcyc(input bit wr, input bit sp, input bit wd, input logic [15:0] d,
                      output logic [15:0] rd, output int waits);
    @(negedge clk);
    h_req = 1; h_wr = wr; h_sel_ptr = sp; h_word = wd; h_wdata = d; waits = 0;
    #1;
    while (!h_ready) begin waits++; @(negedge clk); #1; end
    rd = h_rdata;
    @(posedge clk); #1;
    h_req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic net(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                     output logic [15:0] rd);
    @(negedge clk);
    n_req = 1; n_wr = wr; n_addr = a; n_wdata = d;
    @(posedge clk); #1;
    n_req = 0;
    @(negedge clk);
    rd = n_rdata;
    if (!wr) chk(n_rvalid && n_rdata == rd, "R10 net read valid", n_rvalid, 1);
  endtask

  // kind: 0 ptr write, 1 data write, 2 data read, 3 ptr read
  localparam int NV = 18;
  localparam logic [38:0] VEC [NV] = '{
    {2'd0,1'b0,16'h0010,16'h0000,2'd0,2'd0},
    {2'd1,1'b1,16'h1234,16'h0000,2'd0,2'd0},
    {2'd1,1'b1,16'hABCD,16'h0000,2'd0,2'd0},
    {2'd1,1'b0,16'h0077,16'h0000,2'd0,2'd0},
    {2'd1,1'b0,16'h0088,16'h0000,2'd0,2'd0},
    {2'd3,1'b0,16'h0000,16'h0016,2'd0,2'd0},
    {2'd0,1'b0,16'h0010,16'h0000,2'd0,2'd0},
    {2'd2,1'b1,16'h0000,16'h1234,2'd1,2'd3},
    {2'd2,1'b1,16'h0000,16'hABCD,2'd0,2'd3},
    {2'd2,1'b0,16'h0000,16'h0077,2'd0,2'd3},
    {2'd2,1'b0,16'h0000,16'h0088,2'd0,2'd3},
    {2'd2,1'b1,16'h0000,16'h0000,2'd0,2'd0},
    {2'd2,1'b1,16'h0000,16'h0000,2'd1,2'd3},
    {2'd0,1'b0,16'h001E,16'h0000,2'd0,2'd0},
    {2'd1,1'b1,16'h5555,16'h0000,2'd0,2'd0},
    {2'd2,1'b1,16'h0000,16'h0000,2'd2,2'd0},
    {2'd0,1'b0,16'h001E,16'h0000,2'd0,2'd0},
    {2'd2,1'b1,16'h0000,16'h5555,2'd1,2'd0}
  };

  function automatic string vtag(input logic [1:0] k, input logic wd, input logic [1:0] w);
    if (k == 2'd0) return "R1 ptr write";
    if (k == 2'd1) return "R3 posted write";
    if (k == 2'd3) return "R2 ptr advance";
    if (w == 2'd2) return "R9 retire before read";
    if (w == 2'd1) return "R5 miss read";
    return wd ? "R6 word hit" : "R7 byte hit";
  endfunction

  initial begin
    logic [15:0] rd, nd;
    int w, w2;
    repeat (3) @(posedge clk);
    #1;
    chk(!mem_en && !n_rvalid, "R11 idle after reset", mem_en, 0);
    rst_n = 1;
    hcyc(0, 1, 0, 0, rd, w);
    chk(rd == 0 && w == 0, "R1 ptr reset 0", rd, 0);
    hcyc(0, 0, 1, 0, rd, w);
    chk(w == 1, "R11 first read misses", w, 1);
    idle(3);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      hcyc(v[38:37] != 2'd2 && v[38:37] != 2'd3 ? 1'b1 : 1'b0,
           v[38:37] == 2'd0 || v[38:37] == 2'd3, v[36], v[35:20], rd, w);
      if (v[38] == 1'b1)
        chk(rd == v[19:4], vtag(v[38:37], v[36], v[3:2]), rd, v[19:4]);
      chk(w == int'(v[3:2]), vtag(v[38:37], v[36], v[3:2]), w, v[3:2]);
      idle(int'(v[1:0]));
    end
    chk(mem[8] == 16'h1234 && mem[10] == 16'h8877, "R3 lanes in SRAM", mem[10], 16'h8877);

    // R8: network write discards prefetch
    hcyc(1, 1, 0, 16'h0028, rd, w);
    hcyc(0, 0, 1, 0, rd, w); idle(3);
    net(1, 10'd21, 16'hBEEF, nd);
    hcyc(0, 0, 1, 0, rd, w);
    chk(rd == 16'hBEEF && w == 1, "R8 net write invalidates", rd, 16'hBEEF);
    idle(3);
    // R8: network read keeps prefetch
    net(0, 10'd21, 0, nd);
    chk(nd == 16'hBEEF, "R10 net read data", nd, 16'hBEEF);
    hcyc(0, 0, 1, 0, rd, w);
    chk(w == 0, "R8 net read keeps prefetch", w, 0);
    idle(3);
    // R8: aux activity discards prefetch
    @(negedge clk); aux_act = 1; @(negedge clk); aux_act = 0;
    hcyc(0, 0, 1, 0, rd, w);
    chk(w == 1, "R8 aux activity invalidates", w, 1);
    idle(3);
    // R8: host write discards prefetch of same word
    hcyc(1, 0, 0, 16'h0012, rd, w);
    idle(3);
    hcyc(0, 0, 0, 0, rd, w);
    chk(w == 1 && rd == 16'h0000, "R8 host write invalidates", w, 1);
    hcyc(1, 1, 0, 16'h0030, rd, w);
    hcyc(0, 0, 0, 0, rd, w);
    chk(rd == 16'h0012, "R3 even byte low lane", rd, 16'h0012);

    // R4/R10: network holds the port, second write stalls
    hcyc(1, 1, 0, 16'h0060, rd, w);
    @(negedge clk); n_req = 1; n_wr = 0; n_addr = 10'd5;
    hcyc(1, 0, 1, 16'h1111, rd, w);
    chk(w == 0, "R3 write to empty post", w, 0);
    fork
      hcyc(1, 0, 1, 16'h2222, rd, w2);
      begin
        @(negedge clk); #1;
        chk(mem_en && !mem_we && mem_addr == 10'd5, "R10 net owns port", mem_addr, 5);
        repeat (3) @(negedge clk);
        n_req = 0;
      end
    join
    chk(w2 >= 3, "R4 stall while post full", w2, 3);
    idle(3);
    hcyc(1, 1, 0, 16'h0060, rd, w);
    hcyc(0, 0, 1, 0, rd, w);
    chk(rd == 16'h1111, "R4 first write kept", rd, 16'h1111);
    hcyc(0, 0, 1, 0, rd, w);
    chk(rd == 16'h2222, "R4 second write kept", rd, 16'h2222);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule